// File: doc/BRIEF.md
# Four-lane serial sample deserializer

This block sits behind four serial receive lanes, each carrying one 10-bit sample per frame with the most significant bit sent first. It runs on a single clock at the bit rate, taking one bit per lane per cycle. Once per frame it puts all four rebuilt words on its outputs together and raises a one-cycle valid pulse.

The block can place word boundaries in one of two ways. In the first, a frame reference signal rises together with the first bit of each word, and the block counts bits from there. In the second, the transmitter repeats a fixed training word, and the block searches each lane for it. Each lane then keeps its own bit-slip offset, so lanes that are skewed from one another by up to nine bit periods still line up. While the link lock input is low, the block discards all incoming data.

Top module: `quad_lane_deser`

## Requirements
- R1: For each lane, the first bit of a word after a word boundary appears as bit 9 of that lane's 10-bit output, and the last bit appears as bit 0. Lane n occupies bits [10n+9:10n] of the output bus.
- R2: With the boundary source set to frame reference (use_train = 0), a rising edge of frame_in marks the first bit of a word. Each full 10-bit word then produces exactly one out_valid pulse, visible in the cycle after the word's last bit is sampled.
- R3: A rising edge of frame_in that falls at any position other than the first bit of the current word restarts the bit count at that edge. The next completed word then produces no out_valid pulse.
- R4: While lock_in is low, out_valid stays low, out_words keeps its last value, every lane_aligned bit clears and the bit count returns to the word start. The first bit sampled after lock_in rises is treated as the first bit of a word. The same reset state (all outputs zero) holds after rst_n.
- R5: With train_mode high, a lane sets its lane_aligned bit and latches its offset after the training word 1000101010 (first bit sent = 1) has been found at the same offset on three consecutive frame ends. A lane may lead the receiver's frame by 0 to 9 bit periods.
- R6: With the boundary source set to training (use_train = 1), out_valid is raised only at frame ends where all four lanes were already aligned.
- R7: An aligned lane whose training word does not match at its latched offset, at a frame end with train_mode still high, clears lane_aligned and restarts the search. It needs three new consecutive matches before it is aligned again.
- R8: After train_mode falls, lane_aligned and the per-lane offsets are held. Each lane's data word is then delivered with its own offset applied, so all four words of a frame appear in the same cycle.
- R9: out_valid never stays high for two cycles in a row, and out_words changes only in the cycles where out_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, one bit per lane per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| lock_in | input | 1 | Link lock; data is ignored while low |
| frame_in | input | 1 | Frame reference, rises with the first bit of a word |
| use_train | input | 1 | Boundary source: 0 frame reference, 1 training offsets |
| train_mode | input | 1 | Enables the training-word search and checks |
| lane_in | input | 4 | One serial bit per lane |
| out_words | output | 40 | Four rebuilt words, lane n at [10n+9:10n] |
| out_valid | output | 1 | One-cycle pulse per delivered frame |
| lane_aligned | output | 4 | Per-lane training alignment flag |

## Verification
The assertions assume three things about the inputs. frame_in stays low for at least one cycle between rising edges. Lanes are skewed by less than one word. lock_in and the mode inputs are synchronous to clk. The stimulus meets these conditions by construction:
- the frame reference is a 50 % duty square wave whose only off-grid edge falls in its low half;
- per-lane skews are drawn from 0 to 9;
- every mode change is applied at a falling clock edge and held through whole frames.

Random data never reaches the search, because train_mode is dropped before the first data frame.

// File: rtl/sdl_pkg.sv
package sdl_pkg;
   typedef enum logic {SRC_FRAME = 1'b0, SRC_TRAIN = 1'b1} bnd_src_e;

   function automatic int unsigned slip_bits(input int unsigned w);
      return (w <= 2) ? 1 : $clog2(w);
   endfunction
endpackage

// File: rtl/sdl_framer.sv
module sdl_framer #(
   parameter int unsigned WORD_W = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lock_in,
   input  logic frame_in,
   output logic frame_pt,
   output logic drop_q
);
   localparam int unsigned CW = $clog2(WORD_W);

   logic [CW-1:0] cnt;
   logic          frame_q;
   logic          off_edge;

   assign off_edge = lock_in && frame_in && !frame_q && (cnt != '0);
   assign frame_pt = lock_in && !off_edge && (cnt == CW'(WORD_W - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt     <= '0;
         frame_q <= 1'b0;
         drop_q  <= 1'b0;
      end else begin
         frame_q <= frame_in;
         if (!lock_in) begin
            cnt    <= '0;
            drop_q <= 1'b0;
         end else if (off_edge) begin
            cnt    <= CW'(1);
            drop_q <= 1'b1;
         end else if (cnt == CW'(WORD_W - 1)) begin
            cnt    <= '0;
            drop_q <= 1'b0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   p_count_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(WORD_W - 1));
   p_resync_r3: assert property (@(posedge clk) disable iff (!rst_n)
      off_edge |=> (cnt == CW'(1)) && drop_q);
   p_unlock_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !lock_in |=> (cnt == '0) && !drop_q);
endmodule

// File: rtl/sdl_lane_shift.sv
module sdl_lane_shift #(
   parameter int unsigned WORD_W = 10
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       lock_in,
   input  logic                       bit_in,
   output logic [WORD_W*WORD_W-1:0]   windows
);
   localparam int unsigned SW = 2 * WORD_W - 2;

   logic [SW-1:0] hist_q;
   logic [SW:0]   hist_nx;

   assign hist_nx = {hist_q, bit_in};

   always_ff @(posedge clk) begin
      if (!rst_n || !lock_in) hist_q <= '0;
      else                    hist_q <= hist_nx[SW-1:0];
   end

   for (genvar s = 0; s < WORD_W; s++) begin : g_win
      assign windows[s*WORD_W +: WORD_W] = hist_nx[s +: WORD_W];
   end

   p_unlock_flush_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !lock_in |=> (hist_q == '0));
endmodule

// File: rtl/sdl_lane_align.sv
module sdl_lane_align #(
   parameter int unsigned      WORD_W       = 10,
   parameter logic [WORD_W-1:0] SYNC_WORD   = 10'b1000101010,
   parameter int unsigned      MATCH_FRAMES = 3
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            lock_in,
   input  logic                            train_on,
   input  logic                            frame_pt,
   input  logic [WORD_W*WORD_W-1:0]        windows,
   output logic                            aligned,
   output logic [sdl_pkg::slip_bits(WORD_W)-1:0] slip
);
   localparam int unsigned SB = sdl_pkg::slip_bits(WORD_W);
   localparam int unsigned MB = $clog2(MATCH_FRAMES + 1);

   logic [WORD_W-1:0] hits;
   logic [SB-1:0]     first_s;
   logic [SB-1:0]     cand;
   logic [MB-1:0]     mcnt;
   logic              hit_cur;
   logic              any_hit;

   for (genvar s = 0; s < WORD_W; s++) begin : g_cmp
      assign hits[s] = (windows[s*WORD_W +: WORD_W] == SYNC_WORD);
   end

   assign any_hit = |hits;

   always_comb begin
      first_s = '0;
      hit_cur = 1'b0;
      for (int s = WORD_W - 1; s >= 0; s--) begin
         if (hits[s]) first_s = SB'(s);
         if (slip == SB'(s)) hit_cur = hits[s];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !lock_in) begin
         aligned <= 1'b0;
         slip    <= '0;
         cand    <= '0;
         mcnt    <= '0;
      end else if (frame_pt && train_on) begin
         if (aligned) begin
            if (!hit_cur) begin
               aligned <= 1'b0;
               mcnt    <= '0;
            end
         end else if (any_hit) begin
            if (mcnt != '0 && first_s == cand) begin
               mcnt <= mcnt + 1'b1;
               if (mcnt == MB'(MATCH_FRAMES - 1)) begin
                  aligned <= 1'b1;
                  slip    <= first_s;
               end
            end else begin
               cand <= first_s;
               mcnt <= MB'(1);
            end
         end else begin
            mcnt <= '0;
         end
      end
   end

   p_rise_in_train_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(aligned) |-> $past(train_on && frame_pt && lock_in));
   p_fail_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_in && frame_pt && train_on && aligned && !hit_cur) |=> !aligned);
   p_unlock_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !lock_in |=> !aligned);
   p_slip_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_in && !train_on && aligned) |=> aligned && $stable(slip));
endmodule

// File: rtl/quad_lane_deser.sv
module quad_lane_deser #(
   parameter int unsigned       LANES        = 4,
   parameter int unsigned       WORD_W       = 10,
   parameter logic [WORD_W-1:0] SYNC_WORD    = 10'b1000101010,
   parameter int unsigned       MATCH_FRAMES = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      lock_in,
   input  logic                      frame_in,
   input  logic                      use_train,
   input  logic                      train_mode,
   input  logic [LANES-1:0]          lane_in,
   output logic [LANES*WORD_W-1:0]   out_words,
   output logic                      out_valid,
   output logic [LANES-1:0]          lane_aligned
);
   import sdl_pkg::*;

   localparam int unsigned SB = slip_bits(WORD_W);
   localparam int unsigned WW = WORD_W * WORD_W;

   if (LANES < 1) begin : g_bad_lanes
      $error("LANES must be at least 1");
   end
   if (WORD_W < 2) begin : g_bad_width
      $error("WORD_W must be at least 2");
   end
   if (MATCH_FRAMES < 2) begin : g_bad_match
      $error("MATCH_FRAMES must be at least 2");
   end

   bnd_src_e                 src;
   logic                     frame_pt;
   logic                     drop_q;
   logic                     all_rdy;
   logic [LANES*WORD_W-1:0]  words_now;

   assign src = bnd_src_e'(use_train);

   sdl_framer #(.WORD_W(WORD_W)) u_framer (
      .clk      (clk),
      .rst_n    (rst_n),
      .lock_in  (lock_in),
      .frame_in (frame_in),
      .frame_pt (frame_pt),
      .drop_q   (drop_q)
   );

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [WW-1:0] win;
      logic [SB-1:0] slip;
      logic [SB-1:0] sel;

      sdl_lane_shift #(.WORD_W(WORD_W)) u_shift (
         .clk     (clk),
         .rst_n   (rst_n),
         .lock_in (lock_in),
         .bit_in  (lane_in[l]),
         .windows (win)
      );

      sdl_lane_align #(
         .WORD_W       (WORD_W),
         .SYNC_WORD    (SYNC_WORD),
         .MATCH_FRAMES (MATCH_FRAMES)
      ) u_align (
         .clk      (clk),
         .rst_n    (rst_n),
         .lock_in  (lock_in),
         .train_on (train_mode),
         .frame_pt (frame_pt),
         .windows  (win),
         .aligned  (lane_aligned[l]),
         .slip     (slip)
      );

      assign sel = (src == SRC_TRAIN) ? slip : '0;

      always_comb begin
         words_now[l*WORD_W +: WORD_W] = win[WORD_W-1:0];
         for (int s = 0; s < WORD_W; s++) begin
            if (sel == SB'(s)) words_now[l*WORD_W +: WORD_W] = win[s*WORD_W +: WORD_W];
         end
      end
   end

   assign all_rdy = (src == SRC_TRAIN) ? &lane_aligned : 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_words <= '0;
      end else if (frame_pt && all_rdy && !drop_q) begin
         out_valid <= 1'b1;
         out_words <= words_now;
      end else begin
         out_valid <= 1'b0;
      end
   end

   p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);
   p_words_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> $stable(out_words));
   p_no_valid_unlocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !lock_in |=> !out_valid);
endmodule

// File: tb/quad_lane_deser_test.sv
module quad_lane_deser_test;
   localparam int L = 4;
   localparam int W = 10;
   localparam logic [W-1:0] SYNC = 10'b1000101010;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            lock_in = 1'b0;
   logic            frame_in = 1'b0;
   logic            use_train = 1'b0;
   logic            train_mode = 1'b0;
   logic [L-1:0]    lane_in = '0;
   logic [L*W-1:0]  out_words;
   logic            out_valid;
   logic [L-1:0]    lane_aligned;

   quad_lane_deser uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .lock_in      (lock_in),
      .frame_in     (frame_in),
      .use_train    (use_train),
      .train_mode   (train_mode),
      .lane_in      (lane_in),
      .out_words    (out_words),
      .out_valid    (out_valid),
      .lane_aligned (lane_aligned)
   );

   always #4 clk = ~clk;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   logic [W-1:0]   wd [L][64];
   logic [L*W-1:0] last_words = '0;

   // state of the bench model
   bit    fp_last, vexp, dtag, trm;
   int    jlast;
   int    run [L];
   bit    al [L];
   string atag;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic check_out();
      if (fp_last) begin
         chk(out_valid == vexp, dtag ? "R3 valid after resync" : (trm ? "R6 valid gating" : "R2 valid per frame"),
             64'(out_valid), 64'(vexp));
         if (vexp) begin
            for (int l = 0; l < L; l++)
               chk(out_words[l*W +: W] == wd[l][jlast], trm ? "R8 lane word" : "R1 lane word",
                   64'(out_words[l*W +: W]), 64'(wd[l][jlast]));
            for (int l = 0; l < L; l++) last_words[l*W +: W] = wd[l][jlast];
         end
         if (trm)
            for (int l = 0; l < L; l++)
               chk(lane_aligned[l] == al[l], atag, 64'(lane_aligned[l]), 64'(al[l]));
      end else begin
         chk(out_valid == 1'b0, "R9 single pulse", 64'(out_valid), 64'd0);
         chk(out_words == last_words, "R9 words held", 64'(out_words), 64'(last_words));
      end
   endtask

   task automatic lock_low(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (i > 0) begin
            chk(out_valid == 1'b0, "R4 no valid unlocked", 64'(out_valid), 64'd0);
            chk(out_words == last_words, "R4 words ignored", 64'(out_words), 64'(last_words));
            chk(lane_aligned == '0, "R4 aligned cleared", 64'(lane_aligned), 64'd0);
         end
         lock_in    = 1'b0;
         lane_in    = L'($urandom);
         frame_in   = 1'($urandom);
         train_mode = 1'($urandom);
      end
   endtask

   task automatic session(input bit tr, input int s [L], input int nf, input int ntr,
                          input int bad_f, input int bad_l, input int rs_f, input int rs_p,
                          input string tag_al);
      int  fidx = 0;
      int  fpos = 0;
      bit  drop = 1'b0;
      bit  all;
      bit  m;
      int  q;
      for (int j = 0; j <= nf; j++)
         for (int l = 0; l < L; l++) begin
            wd[l][j] = (tr && j < ntr) ? SYNC : W'($urandom);
            if (j == bad_f && l == bad_l) wd[l][j] = '0;
         end
      for (int l = 0; l < L; l++) begin
         run[l] = 0;
         al[l]  = 1'b0;
      end
      trm = tr; atag = tag_al; fp_last = 1'b0; vexp = 1'b0; dtag = 1'b0; jlast = 0;
      lock_low(20);
      use_train = tr;
      while (fidx < nf) begin
         @(negedge clk);
         check_out();
         if (!tr && fidx == rs_f && fpos == rs_p) begin
            fidx++;
            fpos = 0;
            drop = 1'b1;
         end
         lock_in    = 1'b1;
         train_mode = tr && (fidx < ntr);
         frame_in   = !tr && (fpos < 5);
         for (int l = 0; l < L; l++) begin
            q = fpos + s[l];
            lane_in[l] = (q < W) ? wd[l][fidx][W-1-q] : wd[l][fidx+1][2*W-1-q];
         end
         fp_last = (fpos == W - 1);
         if (fp_last) begin
            jlast = fidx;
            dtag  = drop;
            all   = 1'b1;
            for (int l = 0; l < L; l++) all &= (!tr || al[l]);
            vexp = all && !drop;
            drop = 1'b0;
            if (tr && fidx < ntr)
               for (int l = 0; l < L; l++) begin
                  m = (wd[l][fidx] == SYNC) && (fidx >= 1 || s[l] == 0);
                  run[l] = m ? run[l] + 1 : 0;
                  al[l]  = (run[l] >= 3);
               end
         end
         fpos++;
         if (fpos == W) begin
            fpos = 0;
            fidx++;
         end
      end
      @(negedge clk);
      check_out();
   endtask

   initial begin
      int sr [L];
      void'($urandom(32'h5eed1041));
      repeat (3) @(negedge clk);
      // R4: reset state
      chk(out_valid == 1'b0, "R4 reset valid", 64'(out_valid), 64'd0);
      chk(out_words == '0, "R4 reset words", 64'(out_words), 64'd0);
      chk(lane_aligned == '0, "R4 reset aligned", 64'(lane_aligned), 64'd0);
      rst_n = 1'b1;
      // R1 R2: plain frame-referenced words
      session(1'b0, '{0, 0, 0, 0}, 20, 0, -1, 0, -1, 0, "R5 aligned flag");
      // R3: off-grid frame edge
      session(1'b0, '{0, 0, 0, 0}, 20, 0, -1, 0, 5, 7, "R5 aligned flag");
      // R5 R6 R8: skewed lanes found by training
      session(1'b1, '{0, 3, 7, 9}, 30, 8, -1, 0, -1, 0, "R5 aligned flag");
      // R7: one lane loses its training word mid-training
      session(1'b1, '{2, 0, 5, 1}, 30, 14, 8, 2, -1, 0, "R7 realign flag");
      // mixed random sessions
      for (int k = 0; k < 6; k++) begin
         for (int l = 0; l < L; l++) sr[l] = (k % 2 == 1) ? int'($urandom % 10) : 0;
         session(1'(k % 2), sr, 24, 6 + int'($urandom % 6), -1, 0,
                 3 + int'($urandom % 8), 6 + int'($urandom % 4), "R5 aligned flag");
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule